// File: doc/BRIEF.md
# Asynchronous Serial Byte Transmitter

This block turns bytes held in an external holding register or FIFO into an asynchronous serial bit stream. While it is idle it watches the holding register's empty flag. When a byte is present, it pulls that byte out with a single-cycle read strobe and builds a frame: a low start bit, then 7 or 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits.

Bit timing comes from an enable input that pulses at sixteen times the baud rate. Each bit stays on the line for sixteen of those pulses. Once a byte has been fetched, the frame is held back until a clear-to-send permission input is high.

The frame settings (word length, parity enable, parity mode and stop count) can change at run time. They are captured when the byte is fetched. Four decoded outputs show which phase the machine is in, one output per phase.

Top module: `uart_tx_sm`

## Requirements
- R1: While reset is high and in the first cycle after reset, `st_idle` is 1, `st_start`, `st_shift` and `st_stop` are 0, `txd` is 1 and `hr_rd` is 0.
- R2: In the idle phase with `hr_empty` low, `hr_rd` is high for exactly one clock cycle. In that cycle the byte on `hr_data` and the frame settings are captured, and the next cycle is in the start phase.
- R3: In the start phase `txd` stays 1. The machine leaves the start phase only in a cycle where `ce_16x` and `cts` are both high.
- R4: The frame is a start bit of 0, then the data bits least significant bit first. Outside a frame the line rests at 1.
- R5: Each bit of the frame is held on `txd` for exactly 16 pulses of `ce_16x`. `txd` does not change in a cycle without a pulse.
- R6: `cfg_len7` = 0 sends 8 data bits. `cfg_len7` = 1 sends bits 0 to 6 only, and bit 7 of the byte has no effect on the line.
- R7: With `cfg_par_en` = 1, a parity bit follows the last data bit. `cfg_par_mode` selects it: 0 makes the count of ones over the sent data bits plus parity odd, 1 makes it even, 2 sends 0 and 3 sends 1.
- R8: `cfg_two_stop` = 0 sends one stop bit and 1 sends two. Stop bits are 1.
- R9: Exactly one of `st_idle`, `st_start`, `st_shift`, `st_stop` is high at any time. `st_shift` covers the start, data and parity bits, and `st_stop` covers the stop bits.
- R10: If another byte is waiting when the last stop bit ends, its start bit begins within 10 enable pulses of the middle of that stop bit, with no idle bit time in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_16x | input | 1 | Enable pulse at 16x the baud rate |
| cfg_len7 | input | 1 | 0: 8 data bits, 1: 7 data bits |
| cfg_two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| cfg_par_en | input | 1 | Adds a parity bit |
| cfg_par_mode | input | 2 | 0 odd, 1 even, 2 constant 0, 3 constant 1 |
| hr_empty | input | 1 | Holding register empty flag |
| hr_data | input | 8 | Holding register byte |
| hr_rd | output | 1 | One-cycle read strobe to the holding register |
| cts | input | 1 | Permission to send, active high |
| txd | output | 1 | Serial data out, idles high |
| st_idle | output | 1 | Idle phase |
| st_start | output | 1 | Waiting for permission |
| st_shift | output | 1 | Start, data and parity bits |
| st_stop | output | 1 | Stop bits |

## Verification
There are three internal counters that could go wrong, and each shows up in a different way at the pins.

- **Sample counter.** A fault here moves every later bit edge. It shows up at the mid-bit sample of the first bit after the start bit, so within about 24 enable pulses of the frame starting.
- **Bit count.** A fault here adds or drops a data, parity or stop bit. It shows up as a wrong level at the expected stop-bit position, or as `st_stop` and `st_idle` rising at the wrong time.
- **Parity mode decode.** A fault here flips one bit of the frame.

Problems in the fetch handshake are caught separately: a read strobe that lasts too long, or repeated fetches, appear as read counts that do not match the bytes offered.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_SHIFT = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        PAR_ODD  = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ZERO = 2'd2,
        PAR_ONE  = 2'd3
    } par_mode_e;

    // ones_odd: reduction xor of the data bits actually sent
    function automatic logic parity_bit(input logic ones_odd, input par_mode_e mode);
        case (mode)
            PAR_ODD:  return ~ones_odd;
            PAR_EVEN: return ones_odd;
            PAR_ZERO: return 1'b0;
            default:  return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_sample_cnt.sv
module uart_tx_sample_cnt #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic ce,
    output logic bit_end
);
    localparam int SAMP_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [SAMP_W-1:0] LAST = SAMP_W'(OVERSAMPLE - 1);

    logic [SAMP_W-1:0] cnt;

    assign bit_end = ce && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (ce) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/uart_tx_shreg.sv
module uart_tx_shreg
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] data,
    input  logic              len_short,
    input  logic              par_en,
    input  par_mode_e         par_mode,
    output logic              ser
);
    localparam int FRAME_W = DATA_W + 4;

    logic [FRAME_W-1:0] sh;
    logic [FRAME_W-1:0] frame_nxt;
    logic [DATA_W-1:0]  mask;
    int                 nbits;

    always_comb begin
        nbits = len_short ? DATA_W - 1 : DATA_W;
        mask  = len_short ? {1'b0, {(DATA_W-1){1'b1}}} : {DATA_W{1'b1}};
        frame_nxt    = '1;
        frame_nxt[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nbits) frame_nxt[i+1] = data[i];
        end
        if (par_en) frame_nxt[nbits+1] = parity_bit(^(data & mask), par_mode);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '1;
        end else if (load) begin
            sh <= frame_nxt;
        end else if (shift) begin
            sh <= {1'b1, sh[FRAME_W-1:1]};
        end
    end

    assign ser = sh[0];

endmodule

// File: rtl/uart_tx_sm.sv
module uart_tx_sm
    import uart_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_16x,
    input  logic              cfg_len7,
    input  logic              cfg_two_stop,
    input  logic              cfg_par_en,
    input  logic [1:0]        cfg_par_mode,
    input  logic              hr_empty,
    input  logic [DATA_W-1:0] hr_data,
    output logic              hr_rd,
    input  logic              cts,
    output logic              txd,
    output logic              st_idle,
    output logic              st_start,
    output logic              st_shift,
    output logic              st_stop
);
    localparam int CNT_W = $clog2(DATA_W + 3);

    tx_state_e        st;
    logic [CNT_W-1:0] bits_left;
    logic [1:0]       stops_left;
    logic             bit_end;
    logic             cnt_clr;
    logic             do_shift;
    logic             ser;
    logic [CNT_W-1:0] shift_bits;

    assign hr_rd    = (st == ST_IDLE) && !hr_empty;
    assign cnt_clr  = (st == ST_IDLE) || (st == ST_START);
    assign do_shift = ((st == ST_SHIFT) || (st == ST_STOP)) && bit_end;
    assign shift_bits = CNT_W'(1 + (cfg_len7 ? DATA_W - 1 : DATA_W) + (cfg_par_en ? 1 : 0));

    uart_tx_sample_cnt #(.OVERSAMPLE(OVERSAMPLE)) u_samp (
        .clk     (clk),
        .rst     (rst),
        .clr     (cnt_clr),
        .ce      (ce_16x),
        .bit_end (bit_end)
    );

    uart_tx_shreg #(.DATA_W(DATA_W)) u_shreg (
        .clk       (clk),
        .rst       (rst),
        .load      (hr_rd),
        .shift     (do_shift),
        .data      (hr_data),
        .len_short (cfg_len7),
        .par_en    (cfg_par_en),
        .par_mode  (par_mode_e'(cfg_par_mode)),
        .ser       (ser)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            bits_left  <= '0;
            stops_left <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (!hr_empty) begin
                        st         <= ST_START;
                        bits_left  <= shift_bits;
                        stops_left <= cfg_two_stop ? 2'd2 : 2'd1;
                    end
                end
                ST_START: begin
                    if (ce_16x && cts) st <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (bit_end) begin
                        if (bits_left == CNT_W'(1)) st <= ST_STOP;
                        else bits_left <= bits_left - 1'b1;
                    end
                end
                default: begin
                    if (bit_end) begin
                        if (stops_left == 2'd1) st <= ST_IDLE;
                        else stops_left <= stops_left - 1'b1;
                    end
                end
            endcase
        end
    end

    assign txd      = ((st == ST_SHIFT) || (st == ST_STOP)) ? ser : 1'b1;
    assign st_idle  = (st == ST_IDLE);
    assign st_start = (st == ST_START);
    assign st_shift = (st == ST_SHIFT);
    assign st_stop  = (st == ST_STOP);

    // R2: the read strobe never lasts more than one cycle
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
        hr_rd |=> !hr_rd);

    // R2: a fetch always leads into the start phase
    a_r2_fetch_to_start: assert property (@(posedge clk) disable iff (rst)
        hr_rd |=> st_start);

    // R3: no frame begins without permission
    a_r3_cts_gate: assert property (@(posedge clk) disable iff (rst)
        (st_start && !cts) |=> !st_shift);

    // R4: the first bit of the shift phase is the low start bit
    a_r4_start_low: assert property (@(posedge clk) disable iff (rst)
        $rose(st_shift) |-> !txd);

    // R5: the line holds between enable pulses while a frame is on it
    a_r5_hold_between_pulses: assert property (@(posedge clk) disable iff (rst)
        (st_shift && !ce_16x) |=> $stable(txd));

    // R8: stop bits are high
    a_r8_stop_high: assert property (@(posedge clk) disable iff (rst)
        st_stop |-> txd);

endmodule

// File: tb/uart_tx_sm_bench.sv
module uart_tx_sm_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce_16x = 1'b0;
    logic       cfg_len7 = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic [1:0] cfg_par_mode = 2'd0;
    logic       cts = 1'b1;
    logic       hr_empty;
    logic [7:0] hr_data;
    logic       hr_rd, txd, st_idle, st_start, st_shift, st_stop;

    logic [7:0] q_data [0:7];
    int         q_n = 0;
    int         q_idx = 0;
    int         checks = 0;
    int         fails = 0;
    int         rd_total = 0;
    int         rd_multi = 0;
    logic       rd_prev = 1'b0;
    int         cyc = 0;
    int         ce_phase = 0;

    assign hr_empty = (q_idx >= q_n);
    assign hr_data  = q_data[q_idx % 8];

    uart_tx_sm u_uart_tx_sm (
        .clk(clk), .rst(rst), .ce_16x(ce_16x),
        .cfg_len7(cfg_len7), .cfg_two_stop(cfg_two_stop),
        .cfg_par_en(cfg_par_en), .cfg_par_mode(cfg_par_mode),
        .hr_empty(hr_empty), .hr_data(hr_data), .hr_rd(hr_rd),
        .cts(cts), .txd(txd),
        .st_idle(st_idle), .st_start(st_start), .st_shift(st_shift), .st_stop(st_stop)
    );

    always #2.5 clk = ~clk;

    // enable pulse every second clock, changed away from the active edge
    always @(negedge clk) begin
        ce_phase <= (ce_phase + 1) % 2;
        ce_16x   <= (ce_phase == 1);
    end

    always @(posedge clk) begin
        if (hr_rd) q_idx <= q_idx + 1;
    end

    always @(negedge clk) begin
        if (hr_rd) rd_total <= rd_total + 1;
        if (hr_rd && rd_prev) rd_multi <= rd_multi + 1;
        rd_prev <= hr_rd;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish, actual cycle %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input logic cond, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!cond) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_ce(input int n);
        int got = 0;
        while (got < n) begin
            @(posedge clk);
            if (ce_16x) got++;
        end
        @(negedge clk);
    endtask

    function automatic logic [15:0] exp_bits(input logic [7:0] d, input logic l7,
                                             input logic pe, input logic [1:0] pm);
        logic [15:0] b = '1;
        int nb = l7 ? 7 : 8;
        logic x = l7 ? ^d[6:0] : ^d;
        b[0] = 1'b0;
        for (int i = 0; i < nb; i++) b[i+1] = d[i];
        if (pe) b[nb+1] = (pm == 2'd0) ? ~x : (pm == 2'd1) ? x : (pm == 2'd2) ? 1'b0 : 1'b1;
        return b;
    endfunction

    task automatic push(input logic [7:0] d);
        q_data[q_n % 8] = d;
        q_n = q_n + 1;
    endtask

    // waits for a start bit, then samples every bit in its middle
    task automatic recv(input logic [15:0] exp, input int nbits, input int nstop, input string req);
        int t = 0;
        int bad = 0;
        while (txd !== 1'b0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check(t < 5000, req, t, 0);
        check(st_shift === 1'b1, "R9 shift phase on start bit", st_shift, 1);
        wait_ce(8);
        for (int k = 0; k < nbits; k++) begin
            if (k > 0) wait_ce(16);
            if (txd !== exp[k]) begin
                bad++;
                $display("FAIL %s bit %0d: actual %0d expected %0d", req, k, txd, exp[k]);
            end
            if (k >= nbits - nstop && st_stop !== 1'b1) begin
                bad++;
                $display("FAIL R9 stop phase at bit %0d: actual %0d expected 1", k, st_stop);
            end
        end
        checks = checks + 1;
        if (bad != 0) fails = fails + 1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(st_idle === 1'b1 && st_start === 1'b0 && st_shift === 1'b0 && st_stop === 1'b0,
              "R1 phase outputs in reset", {st_idle, st_start, st_shift, st_stop}, 8);
        check(txd === 1'b1 && hr_rd === 1'b0, "R1 line and strobe in reset", {txd, hr_rd}, 2);
        rst = 1'b0;
        @(negedge clk);
        check(st_idle === 1'b1 && txd === 1'b1, "R1 idle after reset", {st_idle, txd}, 3);
    endtask

    task automatic t_frame(input logic [7:0] d, input logic l7, input logic pe,
                           input logic [1:0] pm, input logic ts, input string req);
        int nbits = 1 + (l7 ? 7 : 8) + (pe ? 1 : 0) + (ts ? 2 : 1);
        cfg_len7 = l7; cfg_par_en = pe; cfg_par_mode = pm; cfg_two_stop = ts;
        cts = 1'b1;
        push(d);
        recv(exp_bits(d, l7, pe, pm), nbits, ts ? 2 : 1, req);
        wait_ce(12);
        check(st_idle === 1'b1 && txd === 1'b1, "R4 line rests high after frame", {st_idle, txd}, 3);
    endtask

    task automatic t_cts_and_strobe();
        int rd0 = rd_total;
        cfg_len7 = 1'b0; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
        cts = 1'b0;
        push(8'h5A);
        repeat (200) @(negedge clk);
        check(st_start === 1'b1 && txd === 1'b1, "R3 held in start without permission", {st_start, txd}, 3);
        check(rd_total - rd0 == 1 && rd_multi == 0, "R2 single one-cycle strobe", rd_total - rd0, 1);
        check(hr_empty === 1'b1, "R2 byte taken from holding register", hr_empty, 1);
        cts = 1'b1;
        recv(exp_bits(8'h5A, 1'b0, 1'b0, 2'd0), 10, 1, "R3 frame after permission");
        wait_ce(12);
    endtask

    task automatic t_bit_len();
        int lo = 0;
        cfg_len7 = 1'b0; cfg_par_en = 1'b0; cfg_two_stop = 1'b0; cts = 1'b1;
        push(8'hA5);
        while (txd !== 1'b0) @(negedge clk);
        while (txd === 1'b0) begin
            @(negedge clk);
            lo++;
        end
        check(lo == 32, "R5 start bit lasts 16 pulses (32 clocks)", lo, 32);
        wait_ce(200);
    endtask

    task automatic t_back_to_back();
        int gap = 0;
        cfg_len7 = 1'b0; cfg_par_en = 1'b0; cfg_two_stop = 1'b0; cts = 1'b1;
        push(8'hC3);
        push(8'h3C);
        recv(exp_bits(8'hC3, 1'b0, 1'b0, 2'd0), 10, 1, "R10 first frame");
        while (txd !== 1'b0 && gap < 100) begin
            @(posedge clk);
            if (ce_16x) gap++;
            @(negedge clk);
        end
        check(gap <= 10, "R10 next start bit follows promptly", gap, 10);
        while (txd === 1'b0) @(negedge clk);
        wait_ce(200);
        check(st_idle === 1'b1 && rd_multi == 0, "R10 both bytes fetched once each", st_idle, 1);
    endtask

    initial begin
        t_reset();
        t_frame(8'hA5, 1'b0, 1'b0, 2'd0, 1'b0, "R4 8 bits no parity 0xA5");
        t_frame(8'hFF, 1'b1, 1'b0, 2'd0, 1'b0, "R6 7 bits, bit 7 ignored 0xFF");
        t_frame(8'h3C, 1'b0, 1'b1, 2'd0, 1'b0, "R7 odd parity 0x3C");
        t_frame(8'h01, 1'b0, 1'b1, 2'd1, 1'b1, "R8 even parity two stops 0x01");
        t_frame(8'h80, 1'b1, 1'b1, 2'd1, 1'b0, "R6 R7 even parity skips bit 7 0x80");
        t_frame(8'h6E, 1'b1, 1'b1, 2'd3, 1'b1, "R7 forced one, two stops");
        t_frame(8'hF7, 1'b0, 1'b1, 2'd2, 1'b0, "R7 forced zero");
        t_cts_and_strobe();
        t_bit_len();
        t_back_to_back();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule